// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits beside the execute stage of a processor core and decides, cycle by cycle, whether an exception or a maskable interrupt is taken. When one is, it carries out the entry sequence: it records the cause code, saves the interrupted PC and PSW into one of two save pairs, and hands back a redirect target and an updated PSW for the core to load. It also performs the matching return-from-trap, restoring PC and PSW from whichever save pair the current nesting depth selects.

Entry has three depths. A first fault or interrupt takes the regular path. A fault raised while a handler is already running (EP set) takes the duplexed path to a fixed vector. A fault raised while a duplexed handler runs (NP set) is unrecoverable: the block writes the cause, PSW and PC as three words to memory through a simple request/acknowledge port and then stops for good, ignoring every input until reset. Results appear one clock after the inputs are sampled.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when at least one request line is high, no exception is presented, no return-from-trap is requested, and the PSW bits ID (bit 12), EP (bit 14) and NP (bit 15) are all zero; otherwise no redirect occurs and no save register changes.
- R2: Among active request lines the highest-numbered one wins; its number L forms the code 0xFE00 | (L << 4), the handler address is 0xFFFF0000 | (code & 0xFFF0), and the new PSW carries L in bits 19:16.
- R3: An exception presented in the same cycle as an active interrupt is the one taken, and the PSW level field in bits 19:16 is left unchanged by an exception entry.
- R4: With EP and NP clear, an entry writes the code to cause bits 15:0, saves PC and PSW to the regular pair, sets EP, and redirects to 0xFFFF0000 | (code & 0xFFF0), except that a computed 0xFFFFFF70 is replaced by 0xFFFFFF60.
- R5: With EP set and NP clear, an entry writes the code to cause bits 31:16, saves PC and PSW to the duplexed pair, sets NP, and redirects to 0xFFFFFFD0, leaving the regular pair and cause bits 15:0 untouched.
- R6: Every entry that redirects clears AE (bit 13), sets ID (bit 12) and keeps all other PSW bits not named in R2 to R5.
- R7: The saved PC is the input PC plus 2 for trap codes 0xFFA0 to 0xFFBF and for an interrupt taken while the halted input is high; otherwise it is the input PC.
- R8: With NP set, an entry issues three word writes in order: 0xFFFF0000 | code to address 0, the PSW to address 4, the PC to address 8; each request with its address and data is held until the acknowledge input is seen high at a clock edge.
- R9: After the third acknowledge the fatal output stays high, and exceptions, interrupts and return-from-trap requests cause no redirect, no write request and no change of any save or cause register until reset.
- R10: A return-from-trap redirects to the duplexed saved PC and PSW when NP is 1 and to the regular saved PC and PSW when NP is 0; an exception in the same cycle takes precedence over it.
- R11: After reset the cause output reads 0x0000FFF0, all save registers read zero, and redirect, write request and fatal outputs are low; each result is registered and appears one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Execute stage presents an exception this cycle |
| exc_code_i | input | 16 | Exception code |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| pc_i | input | 32 | Current PC |
| psw_i | input | 32 | Current PSW |
| halted_i | input | 1 | Core is halted |
| reti_i | input | 1 | Return-from-trap command |
| wr_ack_i | input | 1 | Acknowledge of the dump write |
| redirect_o | output | 1 | Load new PC and PSW this cycle |
| new_pc_o | output | 32 | Redirect target |
| new_psw_o | output | 32 | PSW to load |
| eipc_o | output | 32 | Regular saved PC |
| eipsw_o | output | 32 | Regular saved PSW |
| fepc_o | output | 32 | Duplexed saved PC |
| fepsw_o | output | 32 | Duplexed saved PSW |
| ecr_o | output | 32 | Cause: duplexed code 31:16, regular code 15:0 |
| wr_req_o | output | 1 | Dump write request |
| wr_addr_o | output | 32 | Dump write address |
| wr_data_o | output | 32 | Dump write data |
| fatal_o | output | 1 | Fatal halt reached |

## Verification
The hardest state to reach is the fatal dump, since it needs NP already set, which in normal use only follows a duplexed entry; the stimulus drives the PSW input directly with NP high together with an exception, then withholds the acknowledge for several cycles to show that request, address and data hold, before releasing it for each word. The regular and duplexed save pairs are built up across an ordered vector table so that the later return-from-trap vectors read back values that earlier entries wrote, and the masked-interrupt vectors confirm through the saved PC and cause outputs that nothing changed.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int PSW_ID_BIT  = 12;
   localparam int PSW_AE_BIT  = 13;
   localparam int PSW_EP_BIT  = 14;
   localparam int PSW_NP_BIT  = 15;
   localparam int PSW_LVL_LO  = 16;
   localparam int LVL_W       = 4;
   localparam int CODE_W      = 16;
   localparam int WORD_W      = 32;

   localparam logic [7:0]  IRQ_PREFIX  = 8'hFE;
   localparam logic [10:0] TRAP_PREFIX = 11'h7FD;

   typedef enum logic [1:0] {
      ENT_REGULAR,
      ENT_DUPLEX,
      ENT_FATAL
   } entry_kind_e;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_WORD0,
      DS_WORD1,
      DS_WORD2,
      DS_HALT
   } dump_state_e;

endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
   import exc_pkg::*;
#(
   parameter int NUM_IRQ = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQ-1:0]  irq_i,
   output logic                any_o,
   output logic [LVL_W-1:0]    level_o,
   output logic [NUM_IRQ-1:0]  grant_o
);

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_grant
      if (g == NUM_IRQ - 1) begin : g_top
         assign grant_o[g] = irq_i[g];
      end else begin : g_low
         assign grant_o[g] = irq_i[g] & ~(|irq_i[NUM_IRQ-1:g+1]);
      end
   end

   always_comb begin
      level_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (grant_o[i]) level_o = level_o | LVL_W'(i);
      end
   end

   assign any_o = |irq_i;

   p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   p_grant_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (grant_o != '0) && irq_i[level_o]);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_pkg::*;
#(
   parameter logic [WORD_W-1:0] VEC_BASE      = 32'hFFFF_0000,
   parameter logic [WORD_W-1:0] DUPLEX_VECTOR = 32'hFFFF_FFD0,
   parameter bit                REMAP_EN      = 1'b1,
   parameter logic [WORD_W-1:0] REMAP_FROM    = 32'hFFFF_FF70,
   parameter logic [WORD_W-1:0] REMAP_TO      = 32'hFFFF_FF60
) (
   input  logic                exc_valid_i,
   input  logic [CODE_W-1:0]   exc_code_i,
   input  logic                irq_any_i,
   input  logic [LVL_W-1:0]    irq_level_i,
   input  logic [WORD_W-1:0]   pc_i,
   input  logic [WORD_W-1:0]   psw_i,
   input  logic                halted_i,
   input  logic                reti_i,
   input  logic [WORD_W-1:0]   eipc_i,
   input  logic [WORD_W-1:0]   eipsw_i,
   input  logic [WORD_W-1:0]   fepc_i,
   input  logic [WORD_W-1:0]   fepsw_i,
   output logic                take_o,
   output entry_kind_e         kind_o,
   output logic [CODE_W-1:0]   code_o,
   output logic [WORD_W-1:0]   handler_o,
   output logic [WORD_W-1:0]   save_pc_o,
   output logic [WORD_W-1:0]   entry_psw_o,
   output logic                restore_o,
   output logic [WORD_W-1:0]   restore_pc_o,
   output logic [WORD_W-1:0]   restore_psw_o
);

   logic              irq_take;
   logic              from_irq;
   logic              adv_two;
   logic [WORD_W-1:0] base_vec;
   logic [WORD_W-1:0] regular_vec;

   assign irq_take = irq_any_i & ~exc_valid_i & ~reti_i &
                     ~psw_i[PSW_ID_BIT] & ~psw_i[PSW_EP_BIT] & ~psw_i[PSW_NP_BIT];
   assign take_o   = exc_valid_i | irq_take;
   assign from_irq = ~exc_valid_i;

   assign code_o = exc_valid_i ? exc_code_i
                               : {IRQ_PREFIX, irq_level_i, 4'h0};

   always_comb begin
      if (psw_i[PSW_NP_BIT])      kind_o = ENT_FATAL;
      else if (psw_i[PSW_EP_BIT]) kind_o = ENT_DUPLEX;
      else                        kind_o = ENT_REGULAR;
   end

   assign base_vec = VEC_BASE | {{(WORD_W-CODE_W){1'b0}}, code_o & 16'hFFF0};

   if (REMAP_EN) begin : g_remap
      assign regular_vec = (base_vec == REMAP_FROM) ? REMAP_TO : base_vec;
   end else begin : g_plain
      assign regular_vec = base_vec;
   end

   assign handler_o = (kind_o == ENT_DUPLEX) ? DUPLEX_VECTOR : regular_vec;

   assign adv_two   = from_irq ? halted_i : (code_o[CODE_W-1:5] == TRAP_PREFIX);
   assign save_pc_o = adv_two ? pc_i + WORD_W'(2) : pc_i;

   always_comb begin
      entry_psw_o             = psw_i;
      entry_psw_o[PSW_AE_BIT] = 1'b0;
      entry_psw_o[PSW_ID_BIT] = 1'b1;
      if (kind_o == ENT_DUPLEX) entry_psw_o[PSW_NP_BIT] = 1'b1;
      else                      entry_psw_o[PSW_EP_BIT] = 1'b1;
      if (from_irq) entry_psw_o[PSW_LVL_LO +: LVL_W] = irq_level_i;
   end

   assign restore_o     = reti_i & ~exc_valid_i;
   assign restore_pc_o  = psw_i[PSW_NP_BIT] ? fepc_i  : eipc_i;
   assign restore_psw_o = psw_i[PSW_NP_BIT] ? fepsw_i : eipsw_i;

endmodule

// File: rtl/exc_dump_seq.sv
module exc_dump_seq
   import exc_pkg::*;
#(
   parameter logic [WORD_W-1:0] DUMP_BASE = 32'h0000_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CODE_W-1:0]   code_i,
   input  logic [WORD_W-1:0]   psw_i,
   input  logic [WORD_W-1:0]   pc_i,
   input  logic                wr_ack_i,
   output logic                wr_req_o,
   output logic [WORD_W-1:0]   wr_addr_o,
   output logic [WORD_W-1:0]   wr_data_o,
   output logic                busy_o,
   output logic                fatal_o
);

   localparam int NUM_WORDS = 3;

   dump_state_e               state_q;
   logic [NUM_WORDS-1:0][WORD_W-1:0] word_q;
   logic [1:0]                idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         word_q  <= '0;
      end else begin
         unique case (state_q)
            DS_IDLE: if (start_i) begin
               word_q[0] <= {16'hFFFF, code_i};
               word_q[1] <= psw_i;
               word_q[2] <= pc_i;
               state_q   <= DS_WORD0;
            end
            DS_WORD0: if (wr_ack_i) state_q <= DS_WORD1;
            DS_WORD1: if (wr_ack_i) state_q <= DS_WORD2;
            DS_WORD2: if (wr_ack_i) state_q <= DS_HALT;
            default:  state_q <= DS_HALT;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         DS_WORD1: idx = 2'd1;
         DS_WORD2: idx = 2'd2;
         default:  idx = 2'd0;
      endcase
   end

   assign wr_req_o  = (state_q == DS_WORD0) | (state_q == DS_WORD1) | (state_q == DS_WORD2);
   assign wr_addr_o = wr_req_o ? DUMP_BASE + {{(WORD_W-4){1'b0}}, idx, 2'b00} : '0;
   assign wr_data_o = wr_req_o ? word_q[idx] : '0;
   assign busy_o    = (state_q != DS_IDLE);
   assign fatal_o   = (state_q == DS_HALT);

   p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ack_i) |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

   p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |=> fatal_o && !wr_req_o);

   p_addr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && wr_ack_i && wr_addr_o != DUMP_BASE + 32'd8) |=>
         wr_req_o && (wr_addr_o == $past(wr_addr_o) + 32'd4));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int                NUM_IRQ       = 5,
   parameter logic [WORD_W-1:0] VEC_BASE      = 32'hFFFF_0000,
   parameter logic [WORD_W-1:0] DUPLEX_VECTOR = 32'hFFFF_FFD0,
   parameter bit                REMAP_EN      = 1'b1,
   parameter logic [WORD_W-1:0] REMAP_FROM    = 32'hFFFF_FF70,
   parameter logic [WORD_W-1:0] REMAP_TO      = 32'hFFFF_FF60,
   parameter logic [WORD_W-1:0] DUMP_BASE     = 32'h0000_0000,
   parameter logic [CODE_W-1:0] RESET_CAUSE   = 16'hFFF0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exc_valid_i,
   input  logic [CODE_W-1:0]   exc_code_i,
   input  logic [NUM_IRQ-1:0]  irq_i,
   input  logic [WORD_W-1:0]   pc_i,
   input  logic [WORD_W-1:0]   psw_i,
   input  logic                halted_i,
   input  logic                reti_i,
   input  logic                wr_ack_i,
   output logic                redirect_o,
   output logic [WORD_W-1:0]   new_pc_o,
   output logic [WORD_W-1:0]   new_psw_o,
   output logic [WORD_W-1:0]   eipc_o,
   output logic [WORD_W-1:0]   eipsw_o,
   output logic [WORD_W-1:0]   fepc_o,
   output logic [WORD_W-1:0]   fepsw_o,
   output logic [WORD_W-1:0]   ecr_o,
   output logic                wr_req_o,
   output logic [WORD_W-1:0]   wr_addr_o,
   output logic [WORD_W-1:0]   wr_data_o,
   output logic                fatal_o
);

   if (NUM_IRQ < 1 || NUM_IRQ > (1 << LVL_W)) begin : g_bad_irq
      $error("NUM_IRQ must lie between 1 and 16");
   end
   if (DUMP_BASE[1:0] != 2'b00) begin : g_bad_dump
      $error("DUMP_BASE must be word aligned");
   end
   if (VEC_BASE[CODE_W-1:0] != '0) begin : g_bad_vec
      $error("VEC_BASE low half must be zero");
   end

   logic                irq_any;
   logic [LVL_W-1:0]    irq_level;
   logic [NUM_IRQ-1:0]  irq_grant;
   logic                take;
   entry_kind_e         kind;
   logic [CODE_W-1:0]   code;
   logic [WORD_W-1:0]   handler;
   logic [WORD_W-1:0]   save_pc;
   logic [WORD_W-1:0]   entry_psw;
   logic                restore;
   logic [WORD_W-1:0]   restore_pc;
   logic [WORD_W-1:0]   restore_psw;
   logic                dump_busy;
   logic                active;
   logic                go;
   logic                dump_start;
   logic                entry_q;
   logic [CODE_W-1:0]   ecr_lo_q;
   logic [CODE_W-1:0]   ecr_hi_q;

   exc_irq_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_i   (irq_i),
      .any_o   (irq_any),
      .level_o (irq_level),
      .grant_o (irq_grant)
   );

   exc_entry_calc #(
      .VEC_BASE      (VEC_BASE),
      .DUPLEX_VECTOR (DUPLEX_VECTOR),
      .REMAP_EN      (REMAP_EN),
      .REMAP_FROM    (REMAP_FROM),
      .REMAP_TO      (REMAP_TO)
   ) u_calc (
      .exc_valid_i   (exc_valid_i),
      .exc_code_i    (exc_code_i),
      .irq_any_i     (irq_any),
      .irq_level_i   (irq_level),
      .pc_i          (pc_i),
      .psw_i         (psw_i),
      .halted_i      (halted_i),
      .reti_i        (reti_i),
      .eipc_i        (eipc_o),
      .eipsw_i       (eipsw_o),
      .fepc_i        (fepc_o),
      .fepsw_i       (fepsw_o),
      .take_o        (take),
      .kind_o        (kind),
      .code_o        (code),
      .handler_o     (handler),
      .save_pc_o     (save_pc),
      .entry_psw_o   (entry_psw),
      .restore_o     (restore),
      .restore_pc_o  (restore_pc),
      .restore_psw_o (restore_psw)
   );

   assign active     = ~dump_busy;
   assign go         = active & take;
   assign dump_start = go & (kind == ENT_FATAL);

   exc_dump_seq #(.DUMP_BASE(DUMP_BASE)) u_dump (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (dump_start),
      .code_i    (code),
      .psw_i     (psw_i),
      .pc_i      (pc_i),
      .wr_ack_i  (wr_ack_i),
      .wr_req_o  (wr_req_o),
      .wr_addr_o (wr_addr_o),
      .wr_data_o (wr_data_o),
      .busy_o    (dump_busy),
      .fatal_o   (fatal_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redirect_o <= 1'b0;
         entry_q    <= 1'b0;
         new_pc_o   <= '0;
         new_psw_o  <= '0;
         eipc_o     <= '0;
         eipsw_o    <= '0;
         fepc_o     <= '0;
         fepsw_o    <= '0;
         ecr_lo_q   <= RESET_CAUSE;
         ecr_hi_q   <= '0;
      end else if (go) begin
         redirect_o <= (kind != ENT_FATAL);
         entry_q    <= (kind != ENT_FATAL);
         new_pc_o   <= handler;
         new_psw_o  <= entry_psw;
         case (kind)
            ENT_REGULAR: begin
               ecr_lo_q <= code;
               eipc_o   <= save_pc;
               eipsw_o  <= psw_i;
            end
            ENT_DUPLEX: begin
               ecr_hi_q <= code;
               fepc_o   <= save_pc;
               fepsw_o  <= psw_i;
            end
            default: ;
         endcase
      end else if (active && restore) begin
         redirect_o <= 1'b1;
         entry_q    <= 1'b0;
         new_pc_o   <= restore_pc;
         new_psw_o  <= restore_psw;
      end else begin
         redirect_o <= 1'b0;
         entry_q    <= 1'b0;
      end
   end

   assign ecr_o = {ecr_hi_q, ecr_lo_q};

   p_entry_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      entry_q |-> redirect_o && !new_psw_o[PSW_AE_BIT] && new_psw_o[PSW_ID_BIT]);

   p_irq_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_valid_i && !reti_i && psw_i[PSW_ID_BIT]) |=> !redirect_o);

   p_exc_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid_i && active && !psw_i[PSW_NP_BIT]) |=>
         redirect_o && (new_psw_o[PSW_LVL_LO +: LVL_W] == $past(psw_i[PSW_LVL_LO +: LVL_W])));

   p_quiet_when_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |=> !redirect_o && $stable(ecr_o) && $stable(eipc_o) && $stable(fepc_o));

   p_duplex_keeps_regular_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && kind == ENT_DUPLEX) |=> $stable(eipc_o) && $stable(ecr_o[CODE_W-1:0]));

endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid_i = 1'b0;
   logic [15:0] exc_code_i = '0;
   logic [4:0]  irq_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] psw_i = '0;
   logic        halted_i = 1'b0;
   logic        reti_i = 1'b0;
   logic        wr_ack_i = 1'b0;
   logic        redirect_o;
   logic [31:0] new_pc_o, new_psw_o, eipc_o, eipsw_o, fepc_o, fepsw_o, ecr_o;
   logic        wr_req_o;
   logic [31:0] wr_addr_o, wr_data_o;
   logic        fatal_o;

   always #2 clk = ~clk;

   exc_entry_ctrl u_exc_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
      .irq_i(irq_i), .pc_i(pc_i), .psw_i(psw_i), .halted_i(halted_i), .reti_i(reti_i),
      .wr_ack_i(wr_ack_i), .redirect_o(redirect_o), .new_pc_o(new_pc_o),
      .new_psw_o(new_psw_o), .eipc_o(eipc_o), .eipsw_o(eipsw_o), .fepc_o(fepc_o),
      .fepsw_o(fepsw_o), .ecr_o(ecr_o), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .fatal_o(fatal_o)
   );

   typedef struct packed {
      logic        ev;
      logic [15:0] code;
      logic [4:0]  irq;
      logic [31:0] pc;
      logic [31:0] psw;
      logic        halt;
      logic        reti;
      logic        redir;
      logic [31:0] xpc;
      logic [31:0] xpsw;
      logic [31:0] xeipc;
      logic [31:0] xecr;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [0:NV-1] = '{
      vec_t'{1'b1, 16'hFF90, 5'h00, 32'h100, 32'h0000_2005, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF90, 32'h0000_5005, 32'h100, 32'h0000_FF90},
      vec_t'{1'b1, 16'hFFA3, 5'h00, 32'h200, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFA0, 32'h0000_5000, 32'h202, 32'h0000_FFA3},
      vec_t'{1'b1, 16'hFF70, 5'h00, 32'h300, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF60, 32'h0000_5000, 32'h300, 32'h0000_FF70},
      vec_t'{1'b0, 16'h0000, 5'h0A, 32'h400, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FE30, 32'h0003_5000, 32'h400, 32'h0000_FE30},
      vec_t'{1'b0, 16'h0000, 5'h10, 32'h500, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 32'hFFFF_FE40, 32'h0004_5000, 32'h502, 32'h0000_FE40},
      vec_t'{1'b0, 16'h0000, 5'h01, 32'h540, 32'h0000_1000, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0,         32'h502, 32'h0000_FE40},
      vec_t'{1'b0, 16'h0000, 5'h01, 32'h580, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0,         32'h502, 32'h0000_FE40},
      vec_t'{1'b1, 16'hFF80, 5'h00, 32'h600, 32'h0000_6000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFD0, 32'h0000_D000, 32'h502, 32'hFF80_FE40},
      vec_t'{1'b1, 16'hFF80, 5'h1F, 32'h700, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF80, 32'h0000_5000, 32'h700, 32'hFF80_FF80},
      vec_t'{1'b0, 16'h0000, 5'h00, 32'h0,   32'h0000_8000, 1'b0, 1'b1, 1'b1, 32'h600,       32'h0000_6000, 32'h700, 32'hFF80_FF80},
      vec_t'{1'b0, 16'h0000, 5'h00, 32'h0,   32'h0000_4000, 1'b0, 1'b1, 1'b1, 32'h700,       32'h0000_0000, 32'h700, 32'hFF80_FF80}
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R6";
         1: return "R7";
         2: return "R4";
         3: return "R2";
         4: return "R7";
         5: return "R1";
         6: return "R1";
         7: return "R5";
         8: return "R3";
         default: return "R10";
      endcase
   endfunction

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      exc_valid_i = 1'b0; exc_code_i = '0; irq_i = '0; pc_i = '0;
      psw_i = '0; halted_i = 1'b0; reti_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R11 reset state
      chk("R11", "redirect", {31'd0, redirect_o}, 32'd0);
      chk("R11", "ecr", ecr_o, 32'h0000_FFF0);
      chk("R11", "eipc", eipc_o, 32'd0);
      chk("R11", "fepsw", fepsw_o, 32'd0);
      chk("R11", "wr_req", {31'd0, wr_req_o}, 32'd0);
      chk("R11", "fatal", {31'd0, fatal_o}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         exc_valid_i = TBL[i].ev;   exc_code_i = TBL[i].code; irq_i = TBL[i].irq;
         pc_i = TBL[i].pc;          psw_i = TBL[i].psw;       halted_i = TBL[i].halt;
         reti_i = TBL[i].reti;
         @(posedge clk); #1;
         chk(tag_of(i), "redirect", {31'd0, redirect_o}, {31'd0, TBL[i].redir});
         if (TBL[i].redir) begin
            chk(tag_of(i), "new_pc", new_pc_o, TBL[i].xpc);
            chk(tag_of(i), "new_psw", new_psw_o, TBL[i].xpsw);
         end
         chk(tag_of(i), "eipc", eipc_o, TBL[i].xeipc);
         chk(tag_of(i), "ecr", ecr_o, TBL[i].xecr);
      end
      // R5 duplexed pair contents after vector 7
      chk("R5", "fepc", fepc_o, 32'h600);
      chk("R5", "fepsw", fepsw_o, 32'h0000_6000);
      chk("R4", "eipsw", eipsw_o, 32'h0000_0000);

      // R8 fatal dump
      @(negedge clk);
      exc_valid_i = 1'b1; exc_code_i = 16'hFF90; pc_i = 32'h800; psw_i = 32'h0000_8000;
      @(posedge clk); #1;
      chk("R8", "redirect", {31'd0, redirect_o}, 32'd0);
      chk("R8", "req0", {31'd0, wr_req_o}, 32'd1);
      chk("R8", "addr0", wr_addr_o, 32'h0);
      chk("R8", "data0", wr_data_o, 32'hFFFF_FF90);
      @(negedge clk) clear_inputs();
      repeat (2) @(posedge clk);
      #1;
      chk("R8", "hold addr0", wr_addr_o, 32'h0);
      chk("R8", "hold req0", {31'd0, wr_req_o}, 32'd1);
      @(negedge clk) wr_ack_i = 1'b1;
      @(posedge clk); #1;
      chk("R8", "addr1", wr_addr_o, 32'h4);
      chk("R8", "data1", wr_data_o, 32'h0000_8000);
      @(posedge clk); #1;
      chk("R8", "addr2", wr_addr_o, 32'h8);
      chk("R8", "data2", wr_data_o, 32'h800);
      @(posedge clk); #1;
      chk("R8", "req done", {31'd0, wr_req_o}, 32'd0);
      chk("R9", "fatal", {31'd0, fatal_o}, 32'd1);
      @(negedge clk) wr_ack_i = 1'b0;

      // R9 everything ignored
      @(negedge clk);
      exc_valid_i = 1'b1; exc_code_i = 16'hFF80; irq_i = 5'h1F; pc_i = 32'h900;
      psw_i = 32'h0; reti_i = 1'b1;
      @(posedge clk); #1;
      chk("R9", "redirect", {31'd0, redirect_o}, 32'd0);
      chk("R9", "ecr", ecr_o, 32'hFF80_FF80);
      chk("R9", "eipc", eipc_o, 32'h700);
      chk("R9", "wr_req", {31'd0, wr_req_o}, 32'd0);
      @(negedge clk) exc_valid_i = 1'b0; reti_i = 1'b0;
      @(posedge clk); #1;
      chk("R9", "redirect irq", {31'd0, redirect_o}, 32'd0);
      chk("R9", "fatal held", {31'd0, fatal_o}, 32'd1);

      // R11 reset clears fatal
      @(negedge clk) begin clear_inputs(); rst_n = 1'b0; end
      @(posedge clk); #1;
      @(negedge clk) rst_n = 1'b1;
      chk("R11", "fatal after reset", {31'd0, fatal_o}, 32'd0);
      chk("R11", "ecr after reset", ecr_o, 32'h0000_FFF0);
      chk("R11", "fepc after reset", fepc_o, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule